// File: doc/BRIEF.md
# Hot-Plug Expander Synchronizer

This block keeps an external I/O expander, reached over the shared SMBus master port, consistent with a switch's hot-plug signals for downstream ports 1 to 15. Port 0 is upstream and has no hot-plug signals. Every change of the output image produces a write of the whole image. Every assertion of the expander's active-low interrupt produces a read of the whole input image. The input image that comes back is published with a one-cycle strobe.

No traffic starts before configuration has finished. Traffic also waits while the shared master port is busy, for example with serial EEPROM loading. The block issues transaction-level requests to a separate SMBus master engine. Each request carries a 7-bit target address built from four pins that are latched at reset release. A failed transaction is retried after a fixed back-off.

Top module: `hp_expander_sync`

## Requirements
- R1: The request address is `{1'b1, 1'b0, 1'b1, pins[3:0]}` (bits 6..0), where pins is the value of `addr_pins` on the last clock edge with `rst_n` low. Later pin changes have no effect.
- R2: `req_valid` stays low while `cfg_done` is low or `bus_busy` is high.
- R3: When `hp_out` differs from the image last written successfully (0 after reset), a write request is issued with `req_rd`=0 and `req_wdata` equal to the whole current `hp_out`.
- R4: Several changes of `hp_out` made while a request is outstanding lead to exactly one further write, which carries the latest image.
- R5: The active-low `exp_int_n` passes through a two-flop synchronizer. While the synchronized value is low, a read request is issued with `req_rd`=1.
- R6: The interrupt is level-sensitive. If it is still low after a read completes, another read is issued.
- R7: When a write and a read are both pending, the write is issued first.
- R8: While `req_valid` is high and `ack` is low, `req_valid`, `req_addr`, `req_rd` and `req_wdata` stay unchanged.
- R9: An `ack` with `ack_err` high ends the request. No request follows for BACKOFF cycles. The next request then reflects the current state, so a retried write carries the latest `hp_out`.
- R10: A successful read (`ack` high, `ack_err` low) loads `ack_rdata` into `in_image`, and `in_valid` is high for exactly the following cycle.
- R11: A failed read leaves `in_image` unchanged and does not raise `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; address pins are captured while it is low |
| cfg_done | input | 1 | High once reset-time configuration is complete |
| addr_pins | input | 4 | Expander address pins |
| hp_out | input | OUT_W | Hot-plug output image for ports 1..15 |
| exp_int_n | input | 1 | Expander interrupt, active low, asynchronous |
| bus_busy | input | 1 | Shared master port in use by another agent |
| req_valid | output | 1 | Transaction request pending |
| req_addr | output | 7 | Target 7-bit SMBus address |
| req_rd | output | 1 | 1 = read inputs, 0 = write outputs |
| req_wdata | output | OUT_W | Output image to write |
| ack | input | 1 | Master engine finished the request |
| ack_err | input | 1 | Qualifies ack: NACK or bus error |
| ack_rdata | input | IN_W | Input image returned by a read |
| in_image | output | IN_W | Last successfully read input image |
| in_valid | output | 1 | One-cycle strobe when in_image updates |

## Verification
The hardest situation to reach is a write and a read that are pending together. The synchronizer delays the interrupt by two cycles, so an output change nearly always wins by timing alone. The bench therefore holds `bus_busy` high while it changes `hp_out` and lowers `exp_int_n`, waits for both to settle, and then releases the bus, so that the order reflects only the priority rule. Image coalescing and write retries are forced the same way: `hp_out` is changed while `ack` is withheld, and again inside the back-off window.

// File: rtl/hp_expander_sync.sv
module hp_expander_sync #(
  parameter int OUT_W   = 15,
  parameter int IN_W    = 15,
  parameter int BACKOFF = 16,
  localparam int CW     = $clog2(BACKOFF + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_done,
  input  logic [3:0]       addr_pins,
  input  logic [OUT_W-1:0] hp_out,
  input  logic             exp_int_n,
  input  logic             bus_busy,
  output logic             req_valid,
  output logic [6:0]       req_addr,
  output logic             req_rd,
  output logic [OUT_W-1:0] req_wdata,
  input  logic             ack,
  input  logic             ack_err,
  input  logic [IN_W-1:0]  ack_rdata,
  output logic [IN_W-1:0]  in_image,
  output logic             in_valid
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_t;

  state_t           state;
  logic [3:0]       pins_q;
  logic             int_s1, int_s2;
  logic [OUT_W-1:0] sent_img;
  logic [CW-1:0]    cnt;

  always_ff @(posedge clk)
    if (!rst_n) pins_q <= addr_pins;

  assign req_addr = {3'b101, pins_q};

  wire want_wr = cfg_done && (hp_out != sent_img);
  wire want_rd = cfg_done && !int_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_s1 <= 1'b1;
      int_s2 <= 1'b1;
    end else begin
      int_s1 <= exp_int_n;
      int_s2 <= int_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      req_valid <= 1'b0;
      req_rd    <= 1'b0;
      req_wdata <= '0;
      sent_img  <= '0;
      in_image  <= '0;
      in_valid  <= 1'b0;
      cnt       <= '0;
    end else begin
      in_valid <= 1'b0;
      case (state)
        S_IDLE:
          if (!bus_busy && (want_wr || want_rd)) begin
            req_valid <= 1'b1;
            req_rd    <= !want_wr;
            if (want_wr) req_wdata <= hp_out;
            state     <= S_REQ;
          end
        S_REQ:
          if (ack) begin
            req_valid <= 1'b0;
            if (ack_err) begin
              cnt   <= CW'(BACKOFF - 1);
              state <= S_WAIT;
            end else begin
              state <= S_IDLE;
              if (req_rd) begin
                in_image <= ack_rdata;
                in_valid <= 1'b1;
              end else begin
                sent_img <= req_wdata;
              end
            end
          end
        S_WAIT:
          if (cnt == '0) state <= S_IDLE;
          else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_addr_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[6:4] == 3'b101);

  assert_launch_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(cfg_done) && !$past(bus_busy));

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !ack |=> req_valid && $stable(req_rd) && $stable(req_wdata) && $stable(req_addr));

  assert_wait_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && ack && ack_err |=> !req_valid);

  assert_strobe_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $past(ack && !ack_err && req_rd && req_valid));

  assert_strobe_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> !in_valid);

  assert_fail_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && ack && ack_err |=> $stable(in_image));

endmodule

// File: tb/hp_expander_sync_tb_top.sv
module hp_expander_sync_tb_top;
  localparam int OUT_W = 15, IN_W = 15, BACKOFF = 16;

  logic clk = 0, rst_n = 0, cfg_done = 0, exp_int_n = 1, bus_busy = 0;
  logic [3:0] addr_pins = 4'b1010;
  logic [OUT_W-1:0] hp_out = '0;
  logic ack = 0, ack_err = 0;
  logic [IN_W-1:0] ack_rdata = '0;
  logic req_valid, req_rd, in_valid;
  logic [6:0] req_addr;
  logic [OUT_W-1:0] req_wdata;
  logic [IN_W-1:0] in_image;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  hp_expander_sync #(.OUT_W(OUT_W), .IN_W(IN_W), .BACKOFF(BACKOFF)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .addr_pins(addr_pins),
    .hp_out(hp_out), .exp_int_n(exp_int_n), .bus_busy(bus_busy),
    .req_valid(req_valid), .req_addr(req_addr), .req_rd(req_rd), .req_wdata(req_wdata),
    .ack(ack), .ack_err(ack_err), .ack_rdata(ack_rdata),
    .in_image(in_image), .in_valid(in_valid));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_quiet(input string req, input int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (req_valid) seen++;
    end
    check(req, seen, 0);
  endtask

  task automatic wait_req();
    int t = 0;
    while (!req_valid && t < 1000) begin @(negedge clk); t++; end
  endtask

  task automatic serve(input string req, input logic exp_rd, input logic [OUT_W-1:0] exp_wd,
                       input logic err, input logic [IN_W-1:0] rdata, input int hold);
    logic [6:0] a0; logic r0; logic [OUT_W-1:0] w0;
    int moved = 0;
    wait_req();
    check({req, " request present"}, req_valid, 1);
    check({req, " rd flag"}, req_rd, exp_rd);
    if (!exp_rd) check({req, " write image"}, req_wdata, exp_wd);
    a0 = req_addr; r0 = req_rd; w0 = req_wdata;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (!req_valid || req_addr !== a0 || req_rd !== r0 || req_wdata !== w0) moved++;
    end
    if (hold > 0) check("R8 fields held until ack", moved, 0);
    ack = 1; ack_err = err; ack_rdata = rdata;
    @(negedge clk);
    ack = 0; ack_err = 0;
  endtask

  task automatic measure_gap(input string req);
    int gap = 0;
    while (!req_valid && gap < 1000) begin @(negedge clk); gap++; end
    n_chk++;
    if (gap < BACKOFF || gap > BACKOFF + 2) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, gap, BACKOFF, BACKOFF + 2);
    end
  endtask

  task automatic t_reset_and_gate();
    repeat (3) @(negedge clk);
    check("R2 reset req_valid", req_valid, 0);
    check("R10 reset in_valid", in_valid, 0);
    check("R10 reset in_image", in_image, 0);
    rst_n = 1;
    @(negedge clk);
    addr_pins = 4'b0101;
    hp_out = 15'h0005;
    idle_quiet("R2 no traffic before cfg_done", 10);
    bus_busy = 1; cfg_done = 1;
    idle_quiet("R2 no traffic while bus busy", 6);
    bus_busy = 0;
    wait_req();
    check("R1 address from latched pins", req_addr, 7'b1011010);
    serve("R3 first write", 1'b0, 15'h0005, 1'b0, '0, 0);
    idle_quiet("R3 no repeat after success", 8);
  endtask

  task automatic t_hold();
    hp_out = 15'h0007;
    serve("R3 write on change", 1'b0, 15'h0007, 1'b0, '0, 5);
  endtask

  task automatic t_coalesce();
    hp_out = 15'h0009;
    wait_req();
    hp_out = 15'h000A;
    @(negedge clk);
    hp_out = 15'h000B;
    serve("R4 in-flight write", 1'b0, 15'h0009, 1'b0, '0, 2);
    serve("R4 coalesced write", 1'b0, 15'h000B, 1'b0, '0, 0);
    idle_quiet("R4 single follow-up write", 10);
  endtask

  task automatic t_priority_and_read();
    bus_busy = 1;
    hp_out = 15'h000C;
    exp_int_n = 0;
    repeat (5) @(negedge clk);
    bus_busy = 0;
    serve("R7 write before read", 1'b0, 15'h000C, 1'b0, '0, 0);
    serve("R5 read on interrupt", 1'b1, '0, 1'b0, 15'h1234, 0);
    check("R10 strobe high", in_valid, 1);
    check("R10 image loaded", in_image, 15'h1234);
    @(negedge clk);
    check("R10 strobe one cycle", in_valid, 0);
    wait_req();
    exp_int_n = 1;
    serve("R6 reread while low", 1'b1, '0, 1'b0, 15'h0F0F, 4);
    check("R6 second image", in_image, 15'h0F0F);
    idle_quiet("R5 no read after release", 10);
  endtask

  task automatic t_read_err();
    exp_int_n = 0;
    serve("R11 failing read", 1'b1, '0, 1'b1, 15'h5EAD, 0);
    check("R11 no strobe", in_valid, 0);
    check("R11 image kept", in_image, 15'h0F0F);
    measure_gap("R9 read retry back-off");
    exp_int_n = 1;
    serve("R9 read retried", 1'b1, '0, 1'b0, 15'h00AA, 4);
    check("R10 retry image", in_image, 15'h00AA);
    idle_quiet("R5 quiet after retry", 8);
  endtask

  task automatic t_write_err();
    hp_out = 15'h000D;
    serve("R9 failing write", 1'b0, 15'h000D, 1'b1, '0, 0);
    hp_out = 15'h000E;
    measure_gap("R9 write retry back-off");
    serve("R9 retry latest image", 1'b0, 15'h000E, 1'b0, '0, 0);
    idle_quiet("R9 quiet after retry", 8);
  endtask

  initial begin
    t_reset_and_gate();
    t_hold();
    t_coalesce();
    t_priority_and_read();
    t_read_err();
    t_write_err();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule